// File: doc/BRIEF.md
# SIMD Divergence Mask Controller

This unit holds the per-lane execution mask for a group of threads that share one instruction stream and advance in lockstep. When the stream reaches a two-sided conditional, every lane presents one condition bit. The unit narrows the mask to the lanes that take the first side. On the "else" command it switches to the lanes that take the second side. On the join it restores the mask that was in force before the conditional. When the two sides are both needed, the group spends the time of both: first one side, then the other.

Each open conditional saves its entry mask and its second-side mask on a LIFO stack, so conditionals can nest. A sequencer issues one command per cycle: branch, else, endif, or no-op. It reads back the mask. It also reads two one-cycle skip pulses, which say that the side just entered has no active lane and can be jumped over. A command that would overflow or underflow the stack, or an else with no open first side, raises an error pulse and changes nothing.

Internally, a three-state sequencer tracks where the innermost conditional stands. ST_TOP means no conditional is open. ST_THEN means the first side of the innermost conditional is running. ST_ELSE means its second side is running. The transitions are:
- branch moves any state to ST_THEN.
- else moves ST_THEN to ST_ELSE.
- endif returns to ST_TOP when the last level closes. Otherwise it returns to ST_THEN or ST_ELSE, whichever the enclosing level was in.
- A faulting command keeps the state.

Top module: `dm_mask_unit`

## Requirements
- R1: After reset the mask has all lanes set, the nesting level is 0, and the error and both skip outputs are low.
- R2: An accepted branch (cmd_op=1) sets the mask, in the next cycle, to the old mask AND cond_bits, and raises the level by one.
- R3: An accepted else (cmd_op=2) sets the mask, in the next cycle, to the branch's entry mask AND NOT the cond_bits given with that branch.
- R4: An endif (cmd_op=3) at level 1 or more restores the mask held before the matching branch, and lowers the level by one.
- R5: A lane that is clear in the mask when a branch arrives stays clear on both sides of that branch, whatever its condition bit.
- R6: skip_then pulses for one cycle after a branch whose first-side mask is all zeros. skip_else pulses for one cycle after an else whose mask is all zeros. The two never pulse together.
- R7: Conditionals nest up to DEPTH levels and close in LIFO order, each endif restoring its own entry mask.
- R8: A branch at level DEPTH raises nest_err for one cycle and leaves the mask and the level unchanged.
- R9: An endif or an else at level 0 raises nest_err for one cycle and leaves the mask and the level unchanged.
- R10: A second else on the same level raises nest_err for one cycle and leaves the mask unchanged.
- R11: With cmd_valid low, or with cmd_op=0, the mask and the level hold, and no pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 2 | Command: 0 no-op, 1 branch, 2 else, 3 endif |
| cond_bits | input | LANES | Per-lane condition for a branch |
| lane_mask | output | LANES | Current active-lane mask |
| skip_then | output | 1 | The side just entered by a branch is empty |
| skip_else | output | 1 | The side just entered by an else is empty |
| nest_err | output | 1 | The last command overflowed, underflowed or was misplaced |
| nest_level | output | $clog2(DEPTH+1) | Number of open conditionals |

## Verification
The bench builds the unit with 8 lanes and a stack of 3 levels. The narrow lane count lets hand-picked condition patterns cover the mixed, all-set and all-clear cases. The shallow stack puts the overflow edge three branches away from reset, so a single nested sequence exercises full depth, an overflow attempt, an empty else side, a repeated else and the unwinding of every level.

// File: rtl/dm_pkg.sv
`timescale 1ns/1ps
package dm_pkg;
    typedef enum logic [1:0] {
        OP_NOP    = 2'd0,
        OP_BRANCH = 2'd1,
        OP_ELSE   = 2'd2,
        OP_ENDIF  = 2'd3
    } dm_op_e;

    typedef enum logic [1:0] {
        ST_TOP,
        ST_THEN,
        ST_ELSE
    } dm_state_e;

    typedef enum logic [1:0] {
        SEL_HOLD,
        SEL_TAKE,
        SEL_ALT,
        SEL_RESTORE
    } dm_sel_e;
endpackage

// File: rtl/dm_lane_split.sv
`timescale 1ns/1ps
module dm_lane_split #(
    parameter int LANES = 32
) (
    input  logic [LANES-1:0] act_mask,
    input  logic [LANES-1:0] cond,
    output logic [LANES-1:0] take_mask,
    output logic [LANES-1:0] alt_mask,
    output logic             take_none
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign take_mask[g] = act_mask[g] & cond[g];
        assign alt_mask[g]  = act_mask[g] & ~cond[g];
    end

    assign take_none = ~|take_mask;
endmodule

// File: rtl/dm_mask_stack.sv
`timescale 1ns/1ps
module dm_mask_stack #(
    parameter int LANES = 32,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       mark_else,
    input  logic                       pop,
    input  logic [LANES-1:0]           push_entry,
    input  logic [LANES-1:0]           push_alt,
    output logic [LANES-1:0]           top_entry,
    output logic [LANES-1:0]           top_alt,
    output logic                       below_in_else,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       full,
    output logic                       empty,
    output logic                       last
);
    localparam int LVL_W = $clog2(DEPTH+1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
    localparam logic [LVL_W-1:0] ONE_LVL  = LVL_W'(1);
    localparam logic [LVL_W-1:0] TWO_LVL  = LVL_W'(2);

    logic [LANES-1:0] ent_q [DEPTH];
    logic [LANES-1:0] alt_q [DEPTH];
    logic [DEPTH-1:0] ph_q;
    logic [LVL_W-1:0] lvl_q;

    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] top_idx;
    logic [IDX_W-1:0] below_idx;

    assign wr_idx    = IDX_W'(lvl_q);
    assign top_idx   = IDX_W'(lvl_q - ONE_LVL);
    assign below_idx = IDX_W'(lvl_q - TWO_LVL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= '0;
            ph_q  <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                ent_q[i] <= '0;
                alt_q[i] <= '0;
            end
        end else begin
            if (push) begin
                ent_q[wr_idx] <= push_entry;
                alt_q[wr_idx] <= push_alt;
                ph_q[wr_idx]  <= 1'b0;
                lvl_q         <= lvl_q + ONE_LVL;
            end else if (mark_else) begin
                ph_q[top_idx] <= 1'b1;
            end else if (pop) begin
                lvl_q <= lvl_q - ONE_LVL;
            end
        end
    end

    assign level         = lvl_q;
    assign full          = (lvl_q == FULL_LVL);
    assign empty         = (lvl_q == '0);
    assign last          = (lvl_q == ONE_LVL);
    assign top_entry     = empty ? '0 : ent_q[top_idx];
    assign top_alt       = empty ? '0 : alt_q[top_idx];
    assign below_in_else = (lvl_q >= TWO_LVL) ? ph_q[below_idx] : 1'b0;
endmodule

// File: rtl/dm_nest_fsm.sv
`timescale 1ns/1ps
module dm_nest_fsm
    import dm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic       stack_full,
    input  logic       last_level,
    input  logic       below_in_else,
    output logic       push,
    output logic       mark_else,
    output logic       pop,
    output logic       fault,
    output dm_sel_e    sel
);
    dm_state_e state_q, state_d;
    dm_op_e    op;
    dm_state_e after_pop;

    assign op        = dm_op_e'(cmd_op);
    assign after_pop = last_level ? ST_TOP : (below_in_else ? ST_ELSE : ST_THEN);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_TOP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        push      = 1'b0;
        mark_else = 1'b0;
        pop       = 1'b0;
        fault     = 1'b0;
        sel       = SEL_HOLD;
        if (cmd_valid) begin
            unique case (state_q)
                ST_TOP: begin
                    unique case (op)
                        OP_BRANCH: begin
                            if (stack_full) fault = 1'b1;
                            else begin
                                push = 1'b1; sel = SEL_TAKE; state_d = ST_THEN;
                            end
                        end
                        OP_ELSE:  fault = 1'b1;
                        OP_ENDIF: fault = 1'b1;
                        default: ;
                    endcase
                end
                ST_THEN: begin
                    unique case (op)
                        OP_BRANCH: begin
                            if (stack_full) fault = 1'b1;
                            else begin
                                push = 1'b1; sel = SEL_TAKE; state_d = ST_THEN;
                            end
                        end
                        OP_ELSE: begin
                            mark_else = 1'b1; sel = SEL_ALT; state_d = ST_ELSE;
                        end
                        OP_ENDIF: begin
                            pop = 1'b1; sel = SEL_RESTORE; state_d = after_pop;
                        end
                        default: ;
                    endcase
                end
                ST_ELSE: begin
                    unique case (op)
                        OP_BRANCH: begin
                            if (stack_full) fault = 1'b1;
                            else begin
                                push = 1'b1; sel = SEL_TAKE; state_d = ST_THEN;
                            end
                        end
                        OP_ELSE: fault = 1'b1;
                        OP_ENDIF: begin
                            pop = 1'b1; sel = SEL_RESTORE; state_d = after_pop;
                        end
                        default: ;
                    endcase
                end
                default: state_d = ST_TOP;
            endcase
        end
    end
endmodule

// File: rtl/dm_mask_unit.sv
`timescale 1ns/1ps
module dm_mask_unit
    import dm_pkg::*;
#(
    parameter int LANES = 32,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_valid,
    input  logic [1:0]                 cmd_op,
    input  logic [LANES-1:0]           cond_bits,
    output logic [LANES-1:0]           lane_mask,
    output logic                       skip_then,
    output logic                       skip_else,
    output logic                       nest_err,
    output logic [$clog2(DEPTH+1)-1:0] nest_level
);
    localparam int LVL_W = $clog2(DEPTH+1);

    logic [LANES-1:0] mask_q;
    logic             skip_then_q, skip_else_q, err_q;

    logic [LANES-1:0] take_mask, alt_mask;
    logic             take_none;
    logic [LANES-1:0] top_entry, top_alt;
    logic             below_in_else, full, empty, last;
    logic [LVL_W-1:0] level;
    logic             push, mark_else, pop, fault;
    dm_sel_e          sel;

    dm_lane_split #(.LANES(LANES)) u_split (
        .act_mask  (mask_q),
        .cond      (cond_bits),
        .take_mask (take_mask),
        .alt_mask  (alt_mask),
        .take_none (take_none)
    );

    dm_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_stack (
        .clk           (clk),
        .rst_n         (rst_n),
        .push          (push),
        .mark_else     (mark_else),
        .pop           (pop),
        .push_entry    (mask_q),
        .push_alt      (alt_mask),
        .top_entry     (top_entry),
        .top_alt       (top_alt),
        .below_in_else (below_in_else),
        .level         (level),
        .full          (full),
        .empty         (empty),
        .last          (last)
    );

    dm_nest_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_valid     (cmd_valid),
        .cmd_op        (cmd_op),
        .stack_full    (full),
        .last_level    (last),
        .below_in_else (below_in_else),
        .push          (push),
        .mark_else     (mark_else),
        .pop           (pop),
        .fault         (fault),
        .sel           (sel)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q      <= '1;
            skip_then_q <= 1'b0;
            skip_else_q <= 1'b0;
            err_q       <= 1'b0;
        end else begin
            unique case (sel)
                SEL_TAKE:    mask_q <= take_mask;
                SEL_ALT:     mask_q <= top_alt;
                SEL_RESTORE: mask_q <= top_entry;
                default:     mask_q <= mask_q;
            endcase
            skip_then_q <= (sel == SEL_TAKE) && take_none;
            skip_else_q <= (sel == SEL_ALT) && (top_alt == '0);
            err_q       <= fault;
        end
    end

    assign lane_mask  = mask_q;
    assign skip_then  = skip_then_q;
    assign skip_else  = skip_else_q;
    assign nest_err   = err_q;
    assign nest_level = level;

    logic unused_ok;
    assign unused_ok = empty;
endmodule

// File: rtl/dm_mask_unit_chk.sv
`timescale 1ns/1ps
module dm_mask_unit_chk #(
    parameter int LANES = 32,
    parameter int DEPTH = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cmd_valid,
    input logic [1:0]                 cmd_op,
    input logic [LANES-1:0]           cond_bits,
    input logic [LANES-1:0]           lane_mask,
    input logic                       skip_then,
    input logic                       skip_else,
    input logic                       nest_err,
    input logic [$clog2(DEPTH+1)-1:0] nest_level
);
    localparam int LVL_W = $clog2(DEPTH+1);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    logic br_ok, br_full, end_empty, idle;
    assign br_ok     = cmd_valid && cmd_op == 2'd1 && nest_level != FULL_LVL;
    assign br_full   = cmd_valid && cmd_op == 2'd1 && nest_level == FULL_LVL;
    assign end_empty = cmd_valid && cmd_op == 2'd3 && nest_level == '0;
    assign idle      = !cmd_valid || cmd_op == 2'd0;

    AST_BRANCH_NARROWS: assert property (@(posedge clk) disable iff (!rst_n)
        br_ok |=> lane_mask == ($past(lane_mask) & $past(cond_bits))); // R2
    AST_NO_NEW_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        br_ok |=> (lane_mask & ~$past(lane_mask)) == '0); // R5
    AST_SKIP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_then || skip_else) |-> lane_mask == '0); // R6
    AST_ONE_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        !(skip_then && skip_else)); // R6
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        nest_level <= FULL_LVL); // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        br_full |=> nest_err && $stable(lane_mask) && $stable(nest_level)); // R8
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        end_empty |=> nest_err && $stable(lane_mask) && $stable(nest_level)); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        idle |=> !nest_err && !skip_then && !skip_else
                 && $stable(lane_mask) && $stable(nest_level)); // R11
endmodule

bind dm_mask_unit dm_mask_unit_chk #(.LANES(LANES), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cond_bits  (cond_bits),
    .lane_mask  (lane_mask),
    .skip_then  (skip_then),
    .skip_else  (skip_else),
    .nest_err   (nest_err),
    .nest_level (nest_level)
);

// File: tb/sim_dm_mask_unit.sv
`timescale 1ns/1ps
module sim_dm_mask_unit;
    localparam int LANES = 8;
    localparam int DEPTH = 3;
    localparam int LVL_W = $clog2(DEPTH+1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic [1:0]       cmd_op = 2'd0;
    logic [LANES-1:0] cond_bits = '0;
    logic [LANES-1:0] lane_mask;
    logic             skip_then, skip_else, nest_err;
    logic [LVL_W-1:0] nest_level;

    always #2 clk = ~clk;

    dm_mask_unit #(.LANES(LANES), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cond_bits(cond_bits), .lane_mask(lane_mask), .skip_then(skip_then),
        .skip_else(skip_else), .nest_err(nest_err), .nest_level(nest_level)
    );

    typedef struct {
        logic [LANES-1:0] mask;
        bit               st, se, er;
        int               lvl;
        string            tag;
    } exp_t;

    exp_t q[$];
    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [LANES-1:0] m_mask = '1;
    logic [LANES-1:0] m_ent [DEPTH];
    logic [LANES-1:0] m_alt [DEPTH];
    bit               m_ph  [DEPTH];
    int               m_lvl = 0;

    task automatic issue(input bit v, input logic [1:0] op,
                         input logic [LANES-1:0] c, input string tag);
        exp_t e;
        @(negedge clk);
        cmd_valid = v; cmd_op = op; cond_bits = c;
        e.st = 0; e.se = 0; e.er = 0; e.tag = tag;
        if (v) begin
            case (op)
                2'd1: if (m_lvl == DEPTH) e.er = 1;
                      else begin
                          m_ent[m_lvl] = m_mask;
                          m_alt[m_lvl] = m_mask & ~c;
                          m_ph[m_lvl]  = 0;
                          m_lvl++;
                          m_mask = m_mask & c;
                          e.st = (m_mask == '0);
                      end
                2'd2: if (m_lvl == 0 || m_ph[m_lvl-1]) e.er = 1;
                      else begin
                          m_ph[m_lvl-1] = 1;
                          m_mask = m_alt[m_lvl-1];
                          e.se = (m_mask == '0);
                      end
                2'd3: if (m_lvl == 0) e.er = 1;
                      else begin
                          m_lvl--;
                          m_mask = m_ent[m_lvl];
                      end
                default: ;
            endcase
        end
        e.mask = m_mask;
        e.lvl  = m_lvl;
        q.push_back(e);
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                total++;
                if (lane_mask !== e.mask || skip_then !== e.st || skip_else !== e.se
                    || nest_err !== e.er || int'(nest_level) != e.lvl) begin
                    bad++;
                    $display("FAIL %s: mask=%h st=%b se=%b err=%b lvl=%0d exp mask=%h st=%b se=%b err=%b lvl=%0d",
                             e.tag, lane_mask, skip_then, skip_else, nest_err, nest_level,
                             e.mask, e.st, e.se, e.er, e.lvl);
                end
            end
        end
    end

    initial begin : watchdog
        #200000;
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: run did not end, exp completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        issue(0, 2'd0, 8'h00, "R1 reset state");
        // R2 R3 R4 mixed condition
        issue(1, 2'd1, 8'h5A, "R2 branch narrows");
        issue(1, 2'd2, 8'h00, "R3 else complement");
        issue(1, 2'd3, 8'h00, "R4 endif restore");
        // R9 underflow
        issue(1, 2'd3, 8'h00, "R9 endif at level 0");
        issue(1, 2'd2, 8'h00, "R9 else at level 0");
        // R6 uniform conditions
        issue(1, 2'd1, 8'hFF, "R6 all taken");
        issue(1, 2'd2, 8'h00, "R6 else side empty");
        issue(1, 2'd3, 8'h00, "R4 endif after uniform");
        issue(1, 2'd1, 8'h00, "R6 then side empty");
        issue(1, 2'd2, 8'h00, "R6 else full");
        issue(1, 2'd3, 8'h00, "R4 endif after none");
        // R5 R7 R8 R10 nesting
        issue(1, 2'd1, 8'h0F, "R7 level 1");
        issue(1, 2'd1, 8'h33, "R5 inactive lanes stay clear");
        issue(1, 2'd2, 8'h00, "R5 else keeps inactive lanes clear");
        issue(1, 2'd1, 8'hFF, "R7 level 3");
        issue(1, 2'd1, 8'hFF, "R8 overflow");
        issue(1, 2'd2, 8'h00, "R6 nested else empty");
        issue(1, 2'd2, 8'h00, "R10 second else");
        issue(1, 2'd3, 8'h00, "R7 pop level 3");
        issue(1, 2'd3, 8'h00, "R7 pop level 2");
        issue(1, 2'd3, 8'h00, "R7 pop level 1");
        // R11 idle and no-op
        issue(0, 2'd1, 8'h00, "R11 valid low ignored");
        issue(1, 2'd0, 8'h00, "R11 no-op ignored");
        issue(1, 2'd1, 8'hC3, "R2 branch after idle");
        issue(0, 2'd2, 8'h00, "R11 valid low inside branch");
        issue(1, 2'd3, 8'h00, "R4 final restore");
        issue(0, 2'd0, 8'h00, "R11 idle");
        repeat (3) @(negedge clk);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule